// File: doc/BRIEF.md
# Channel Event Flag Bank with Overflow Tracking

This block keeps sticky per-channel event flags for a multi-channel timer co-processor. The engine side delivers one-cycle event pulses per channel on two separate event classes: channel interrupts and data transfer requests. Each class has its own status flag per channel, set by a pulse and cleared by the host. Each class also has its own overflow flag per channel, which records that a fresh pulse arrived while the status flag was still pending. A single global exception flag sits beside the two classes and has no overflow flag.

The host sees the flags through a small register space. It can use global vector registers, which hold one bit per channel, or a per-channel register that gathers every flag and enable of one channel. Status and overflow flags are write-one-to-clear. Each class also has a per-channel enable. A level output per channel is high while that channel's status flag and its enable are both set. Host reads are combinational on the address. Writes take effect at the next rising clock edge.

Top module: `chan_evt_status`

## Requirements
- R1: A pulse on `irqEvt[i]` sets interrupt status flag i at the next clock edge. A pulse on `xfrEvt[i]` sets transfer status flag i at the next clock edge.
- R2: A pulse that arrives while status flag i of the same class is already set, with no clear of that status flag in the same cycle, sets overflow flag i of that class at the next edge.
- R3: A status flag clears when the host writes a 1 to it: bit i of the class's status vector register, or the status field of the channel register. Writing 0 leaves the flag unchanged. Clearing a status flag never changes the overflow flag. Without a pulse or a clear, a status flag holds its value.
- R4: An overflow flag clears only when the host writes a 1 to it: bit i of the class's overflow vector register, or the overflow field of the channel register. Otherwise it holds its value.
- R5: If a pulse and a host status clear hit the same channel in the same cycle, the status flag ends up set and the overflow flag keeps its prior value, whether that value is 0 or 1.
- R6: If a host overflow clear and a new overflow condition hit the same channel in the same cycle, the overflow flag ends up set.
- R7: The transfer request class works in the same way as the interrupt class. Its flags and enables are independent: address 2 is the status vector, 3 the overflow vector and 5 the enable vector. In the channel register its fields are bit 2 (status), bit 3 (overflow) and bit 5 (enable).
- R8: `irqLine[i]` is high exactly when interrupt status i and interrupt enable i are both set, and `xfrLine[i]` works the same way for its class. Enables are plain read/write: address 4 holds the interrupt vector and address 5 the transfer vector. Bit 4 of the channel register is the interrupt enable of that channel and bit 5 its transfer enable.
- R9: Register map, with read data available in the same cycle as the address. Addresses 0 and 1 are the interrupt status and overflow vectors, with bit i standing for channel i. Addresses with the top address bit set select the channel register of the channel given by the low address bits. Its bits are 0 = interrupt status, 1 = interrupt overflow, 2 = transfer status, 3 = transfer overflow, 4 = interrupt enable and 5 = transfer enable; all other bits read 0. Any other address reads 0 and ignores writes.
- R10: The exception flag reads at address 6 bit 0 and drives `excFlag`. It is set by `excEvt` and cleared by writing 1 to address 6 bit 0. A set in the same cycle as a clear wins. It has no overflow flag, and the other bits of address 6 read 0.
- R11: After reset, all flags and enables are 0, so every register reads 0 and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| irqEvt | input | NUM_CH | One-cycle interrupt event pulses, one per channel |
| xfrEvt | input | NUM_CH | One-cycle transfer request event pulses, one per channel |
| excEvt | input | 1 | Global exception event pulse |
| hostWe | input | 1 | Host write strobe for the current address |
| hostAddr | input | ADDR_W | Host register address |
| hostWrData | input | DATA_W | Host write data |
| hostRdData | output | DATA_W | Host read data for `hostAddr`, combinational |
| irqLine | output | NUM_CH | Per-channel interrupt level (status and enable) |
| xfrLine | output | NUM_CH | Per-channel transfer request level (status and enable) |
| excFlag | output | 1 | Global exception flag |

## Verification
The bound checker watches every channel on every cycle. It checks that a pulse sets its status flag, and that a repeated pulse with no host write sets overflow. It also checks that a new overflow always follows a pending status, that overflow and status hold while the host is idle, and that a level output never rises without its status flag. Which write wins when a write meets an event on the same cycle (R5, R6) is only shown by the bench scenarios. The same is true of the write-one-to-clear masking by data bits, the register layout and mirroring between vector and channel views (R9), and the behaviour of the exception flag under clears. For these, the bench runs a sweep over every channel, targeted coincidence cases and a long pseudo-random mix, all compared with a model built from the requirements.

// File: rtl/chan_evt_pkg.sv
package chan_evt_pkg;

  // event classes served by one datapath instance each
  localparam int KIND_IRQ = 0;
  localparam int KIND_XFR = 1;
  localparam int KIND_EXC = 2;
  localparam int NUM_KIND = 3;

  // global register numbers (top address bit clear)
  localparam int REG_IRQ_STAT = 0;
  localparam int REG_IRQ_OVF  = 1;
  localparam int REG_XFR_STAT = 2;
  localparam int REG_XFR_OVF  = 3;
  localparam int REG_IRQ_EN   = 4;
  localparam int REG_XFR_EN   = 5;
  localparam int REG_EXC      = 6;

  // field positions inside the channel register
  localparam int FLD_IRQ_STAT = 0;
  localparam int FLD_IRQ_OVF  = 1;
  localparam int FLD_XFR_STAT = 2;
  localparam int FLD_XFR_OVF  = 3;
  localparam int FLD_IRQ_EN   = 4;
  localparam int FLD_XFR_EN   = 5;

  // strobes from the host decoder to one flag datapath
  typedef struct packed {
    logic vecStatClr;   // clear status bits selected by write data
    logic vecOvfClr;    // clear overflow bits selected by write data
    logic vecEnWr;      // load enable vector from write data
    logic chanStatClr;  // clear status bit of the addressed channel
    logic chanOvfClr;   // clear overflow bit of the addressed channel
    logic chanEnWr;     // load enable bit of the addressed channel
    logic chanEnVal;    // value for chanEnWr
  } flagStrobe_t;

endpackage

// File: rtl/chan_evt_dp.sv
module chan_evt_dp
  import chan_evt_pkg::*;
#(
  parameter int NUM_CH    = 32,
  parameter int IDX_W     = 5,
  parameter bit TRACK_OVF = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] evt,
  input  flagStrobe_t       strobe,
  input  logic [NUM_CH-1:0] wrVec,
  input  logic [IDX_W-1:0]  chanIdx,
  output logic [NUM_CH-1:0] stat,
  output logic [NUM_CH-1:0] ovf,
  output logic [NUM_CH-1:0] en,
  output logic [NUM_CH-1:0] line
);

  logic [NUM_CH-1:0] chanMask;
  logic [NUM_CH-1:0] statClr;

  assign chanMask = NUM_CH'(1) << chanIdx;

  assign statClr = (strobe.vecStatClr  ? wrVec    : '0)
                 | (strobe.chanStatClr ? chanMask : '0);

  // status: a pulse beats a coincident clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stat <= '0;
    end else begin
      stat <= (stat & ~statClr) | evt;
    end
  end

  generate
    if (TRACK_OVF) begin : g_ovf
      logic [NUM_CH-1:0] ovfClr;
      logic [NUM_CH-1:0] ovfSet;

      assign ovfClr = (strobe.vecOvfClr  ? wrVec    : '0)
                    | (strobe.chanOvfClr ? chanMask : '0);
      // repeat pulse on a pending flag, unless the flag is cleared this cycle
      assign ovfSet = evt & stat & ~statClr;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          ovf <= '0;
        end else begin
          ovf <= (ovf & ~ovfClr) | ovfSet;
        end
      end
    end else begin : g_noOvf
      logic unusedOvfStrobes;
      assign unusedOvfStrobes = strobe.vecOvfClr ^ strobe.chanOvfClr;
      assign ovf = '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      en <= '0;
    end else if (strobe.vecEnWr) begin
      en <= wrVec;
    end else if (strobe.chanEnWr) begin
      en <= (en & ~chanMask) | (strobe.chanEnVal ? chanMask : '0);
    end
  end

  assign line = stat & en;

endmodule

// File: rtl/chan_evt_ctrl.sv
module chan_evt_ctrl
  import chan_evt_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5,
  parameter int ADDR_W = 6
) (
  input  logic                       hostWe,
  input  logic [ADDR_W-1:0]          hostAddr,
  input  logic [DATA_W-1:0]          hostWrData,
  input  logic [NUM_CH-1:0]          irqStat,
  input  logic [NUM_CH-1:0]          irqOvf,
  input  logic [NUM_CH-1:0]          irqEn,
  input  logic [NUM_CH-1:0]          xfrStat,
  input  logic [NUM_CH-1:0]          xfrOvf,
  input  logic [NUM_CH-1:0]          xfrEn,
  input  logic                       excStat,
  output flagStrobe_t [NUM_KIND-1:0] strobe,
  output logic [IDX_W-1:0]           chanIdx,
  output logic [DATA_W-1:0]          hostRdData
);

  logic              chanSel;
  logic [ADDR_W-2:0] regNum;

  assign chanSel = hostAddr[ADDR_W-1];
  assign regNum  = hostAddr[ADDR_W-2:0];
  assign chanIdx = hostAddr[IDX_W-1:0];

  // write decode: class k uses registers 2k, 2k+1, 4+k and fields 2k, 2k+1, 4+k
  always_comb begin
    strobe = '0;
    for (int k = 0; k < 2; k++) begin
      strobe[k].vecStatClr  = hostWe && !chanSel && (int'(regNum) == REG_IRQ_STAT + 2*k);
      strobe[k].vecOvfClr   = hostWe && !chanSel && (int'(regNum) == REG_IRQ_OVF + 2*k);
      strobe[k].vecEnWr     = hostWe && !chanSel && (int'(regNum) == REG_IRQ_EN + k);
      strobe[k].chanStatClr = hostWe && chanSel && hostWrData[FLD_IRQ_STAT + 2*k];
      strobe[k].chanOvfClr  = hostWe && chanSel && hostWrData[FLD_IRQ_OVF + 2*k];
      strobe[k].chanEnWr    = hostWe && chanSel;
      strobe[k].chanEnVal   = hostWrData[FLD_IRQ_EN + k];
    end
    strobe[KIND_EXC].vecStatClr = hostWe && !chanSel && (int'(regNum) == REG_EXC);
  end

  // read mux
  always_comb begin
    hostRdData = '0;
    if (chanSel) begin
      hostRdData[FLD_IRQ_STAT] = irqStat[chanIdx];
      hostRdData[FLD_IRQ_OVF]  = irqOvf[chanIdx];
      hostRdData[FLD_XFR_STAT] = xfrStat[chanIdx];
      hostRdData[FLD_XFR_OVF]  = xfrOvf[chanIdx];
      hostRdData[FLD_IRQ_EN]   = irqEn[chanIdx];
      hostRdData[FLD_XFR_EN]   = xfrEn[chanIdx];
    end else begin
      case (int'(regNum))
        REG_IRQ_STAT: hostRdData[NUM_CH-1:0] = irqStat;
        REG_IRQ_OVF:  hostRdData[NUM_CH-1:0] = irqOvf;
        REG_XFR_STAT: hostRdData[NUM_CH-1:0] = xfrStat;
        REG_XFR_OVF:  hostRdData[NUM_CH-1:0] = xfrOvf;
        REG_IRQ_EN:   hostRdData[NUM_CH-1:0] = irqEn;
        REG_XFR_EN:   hostRdData[NUM_CH-1:0] = xfrEn;
        REG_EXC:      hostRdData[0]          = excStat;
        default:      hostRdData             = '0;
      endcase
    end
  end

endmodule

// File: rtl/chan_evt_status.sv
module chan_evt_status
  import chan_evt_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int DATA_W = 32,
  localparam int IDX_W  = $clog2(NUM_CH),
  localparam int ADDR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] irqEvt,
  input  logic [NUM_CH-1:0] xfrEvt,
  input  logic              excEvt,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  output logic [NUM_CH-1:0] irqLine,
  output logic [NUM_CH-1:0] xfrLine,
  output logic              excFlag
);

  flagStrobe_t [NUM_KIND-1:0] strobe;
  logic [IDX_W-1:0]  chanIdx;
  logic [NUM_CH-1:0] irqStat, irqOvf, irqEn;
  logic [NUM_CH-1:0] xfrStat, xfrOvf, xfrEn;
  logic              excStat;
  logic              unusedExcOvf, unusedExcEn, unusedExcLine;

  chan_evt_ctrl #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .hostWe    (hostWe),
    .hostAddr  (hostAddr),
    .hostWrData(hostWrData),
    .irqStat   (irqStat),
    .irqOvf    (irqOvf),
    .irqEn     (irqEn),
    .xfrStat   (xfrStat),
    .xfrOvf    (xfrOvf),
    .xfrEn     (xfrEn),
    .excStat   (excStat),
    .strobe    (strobe),
    .chanIdx   (chanIdx),
    .hostRdData(hostRdData)
  );

  chan_evt_dp #(.NUM_CH(NUM_CH), .IDX_W(IDX_W), .TRACK_OVF(1'b1)) u_irqDp (
    .clk    (clk),
    .rstN   (rstN),
    .evt    (irqEvt),
    .strobe (strobe[KIND_IRQ]),
    .wrVec  (hostWrData[NUM_CH-1:0]),
    .chanIdx(chanIdx),
    .stat   (irqStat),
    .ovf    (irqOvf),
    .en     (irqEn),
    .line   (irqLine)
  );

  chan_evt_dp #(.NUM_CH(NUM_CH), .IDX_W(IDX_W), .TRACK_OVF(1'b1)) u_xfrDp (
    .clk    (clk),
    .rstN   (rstN),
    .evt    (xfrEvt),
    .strobe (strobe[KIND_XFR]),
    .wrVec  (hostWrData[NUM_CH-1:0]),
    .chanIdx(chanIdx),
    .stat   (xfrStat),
    .ovf    (xfrOvf),
    .en     (xfrEn),
    .line   (xfrLine)
  );

  // global exception: single flag, overflow tracking generated out
  chan_evt_dp #(.NUM_CH(1), .IDX_W(1), .TRACK_OVF(1'b0)) u_excDp (
    .clk    (clk),
    .rstN   (rstN),
    .evt    (excEvt),
    .strobe (strobe[KIND_EXC]),
    .wrVec  (hostWrData[0]),
    .chanIdx(1'b0),
    .stat   (excStat),
    .ovf    (unusedExcOvf),
    .en     (unusedExcEn),
    .line   (unusedExcLine)
  );

  assign excFlag = excStat;

endmodule

// File: rtl/chan_evt_chk.sv
module chan_evt_chk #(
  parameter int NUM_CH = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostWe,
  input logic [NUM_CH-1:0] irqEvt,
  input logic [NUM_CH-1:0] xfrEvt,
  input logic              excEvt,
  input logic [NUM_CH-1:0] irqStat,
  input logic [NUM_CH-1:0] irqOvf,
  input logic [NUM_CH-1:0] xfrStat,
  input logic [NUM_CH-1:0] xfrOvf,
  input logic [NUM_CH-1:0] irqLine,
  input logic [NUM_CH-1:0] xfrLine,
  input logic              excFlag
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    p_irq_set_r1: assert property (@(posedge clk) disable iff (!rstN)
      irqEvt[i] |=> irqStat[i]);
    p_xfr_set_r7: assert property (@(posedge clk) disable iff (!rstN)
      xfrEvt[i] |=> xfrStat[i]);
    p_irq_ovf_r2: assert property (@(posedge clk) disable iff (!rstN)
      (irqEvt[i] && irqStat[i] && !hostWe) |=> irqOvf[i]);
    p_xfr_ovf_r7: assert property (@(posedge clk) disable iff (!rstN)
      (xfrEvt[i] && xfrStat[i] && !hostWe) |=> xfrOvf[i]);
    p_ovf_origin_r2: assert property (@(posedge clk) disable iff (!rstN)
      $rose(irqOvf[i]) |-> $past(irqStat[i]));
    p_irq_ovf_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
      (irqOvf[i] && !hostWe) |=> irqOvf[i]);
    p_xfr_ovf_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
      (xfrOvf[i] && !hostWe) |=> xfrOvf[i]);
    p_stat_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
      (!hostWe && !irqEvt[i]) |=> $stable(irqStat[i]));
    p_irq_line_r8: assert property (@(posedge clk) disable iff (!rstN)
      irqLine[i] |-> irqStat[i]);
    p_xfr_line_r8: assert property (@(posedge clk) disable iff (!rstN)
      xfrLine[i] |-> xfrStat[i]);
  end

  p_exc_set_r10: assert property (@(posedge clk) disable iff (!rstN)
    excEvt |=> excFlag);

endmodule

bind chan_evt_status chan_evt_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .hostWe (hostWe),
  .irqEvt (irqEvt),
  .xfrEvt (xfrEvt),
  .excEvt (excEvt),
  .irqStat(irqStat),
  .irqOvf (irqOvf),
  .xfrStat(xfrStat),
  .xfrOvf (xfrOvf),
  .irqLine(irqLine),
  .xfrLine(xfrLine),
  .excFlag(excFlag)
);

// File: tb/chan_evt_status_test.sv
module chan_evt_status_test;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] irqEvt = '0, xfrEvt = '0;
  logic        excEvt = 1'b0;
  logic        hostWe = 1'b0;
  logic [5:0]  hostAddr = '0;
  logic [31:0] hostWrData = '0;
  logic [31:0] hostRdData;
  logic [31:0] irqLine, xfrLine;
  logic        excFlag;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 0;

  // model state: index 0 = interrupt class, 1 = transfer class
  logic [31:0] mStat [2];
  logic [31:0] mOvf  [2];
  logic [31:0] mEn   [2];
  logic        mExc;
  logic [31:0] seed = 32'h1234_5678;

  chan_evt_status #(.NUM_CH(NCH), .DATA_W(32)) uut (
    .clk(clk), .rstN(rstN), .irqEvt(irqEvt), .xfrEvt(xfrEvt), .excEvt(excEvt),
    .hostWe(hostWe), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .hostRdData(hostRdData), .irqLine(irqLine), .xfrLine(xfrLine), .excFlag(excFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] nextRnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic logic [31:0] rdModel(logic [5:0] a);
    logic [31:0] r = '0;
    if (a[5]) begin
      r[0] = mStat[0][a[4:0]];
      r[1] = mOvf[0][a[4:0]];
      r[2] = mStat[1][a[4:0]];
      r[3] = mOvf[1][a[4:0]];
      r[4] = mEn[0][a[4:0]];
      r[5] = mEn[1][a[4:0]];
    end else begin
      case (a)
        6'd0: r = mStat[0];
        6'd1: r = mOvf[0];
        6'd2: r = mStat[1];
        6'd3: r = mOvf[1];
        6'd4: r = mEn[0];
        6'd5: r = mEn[1];
        6'd6: r = {31'b0, mExc};
        default: r = '0;
      endcase
    end
    return r;
  endfunction

  task automatic modelUpdate(logic [31:0] evI, logic [31:0] evX, logic evE,
                             logic we, logic [5:0] a, logic [31:0] d);
    logic [31:0] ev [2];
    ev[0] = evI;
    ev[1] = evX;
    for (int k = 0; k < 2; k++) begin
      logic [31:0] sc = '0, oc = '0, setO;
      if (we && a[5]) begin
        sc[a[4:0]] = d[2*k];
        oc[a[4:0]] = d[2*k+1];
        mEn[k][a[4:0]] = d[4+k];
      end else if (we) begin
        if (a == 6'(2*k))   sc = d;
        if (a == 6'(2*k+1)) oc = d;
        if (a == 6'(4+k))   mEn[k] = d;
      end
      setO = ev[k] & mStat[k] & ~sc;
      mOvf[k]  = (mOvf[k] & ~oc) | setO;
      mStat[k] = (mStat[k] & ~sc) | ev[k];
    end
    mExc = (mExc & ~(we && a == 6'd6 && d[0])) | evE;
  endtask

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(logic [31:0] evI, logic [31:0] evX, logic evE,
                      logic we, logic [5:0] a, logic [31:0] d, string tag);
    @(negedge clk);
    irqEvt = evI; xfrEvt = evX; excEvt = evE;
    hostWe = we; hostAddr = a; hostWrData = d;
    #1;
    check(tag, "read", hostRdData, rdModel(a));
    @(posedge clk);
    modelUpdate(evI, evX, evE, we, a, d);
    #1;
    check(tag, "irqLine", irqLine, mStat[0] & mEn[0]);
    check(tag, "xfrLine", xfrLine, mStat[1] & mEn[1]);
    check(tag, "excFlag", {31'b0, excFlag}, {31'b0, mExc});
  endtask

  task automatic rd(logic [5:0] a, string tag);
    step('0, '0, 1'b0, 1'b0, a, '0, tag);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    for (int k = 0; k < 2; k++) begin
      mStat[k] = '0; mOvf[k] = '0; mEn[k] = '0;
    end
    mExc = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R11: reset state, all addresses
    for (int a = 0; a < 64; a++) begin
      if (a < 8 || a >= 32) rd(6'(a), "R11");
    end

    // per-channel sweep of both classes
    for (int ch = 0; ch < NCH; ch++) begin
      logic [31:0] m = 32'd1 << ch;
      step(m, '0, 1'b0, 1'b0, 6'd0, '0, "R1");
      step(m, '0, 1'b0, 1'b0, 6'(32 + ch), '0, "R2");
      rd(6'd1, "R2");
      step('0, '0, 1'b0, 1'b1, 6'(32 + ch), 32'h1, "R3");
      rd(6'(32 + ch), "R3");
      step('0, '0, 1'b0, 1'b1, 6'd1, m, "R4");
      rd(6'd1, "R4");
      step('0, m, 1'b0, 1'b0, 6'd2, '0, "R7");
      step('0, m, 1'b0, 1'b0, 6'(32 + ch), '0, "R7");
      step('0, '0, 1'b0, 1'b1, 6'd2, m, "R7");
      step('0, '0, 1'b0, 1'b1, 6'(32 + ch), 32'h8, "R7");
      rd(6'(32 + ch), "R9");
    end

    // R3: writing zero leaves flags alone
    step(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, 6'd0, '0, "R3");
    step('0, '0, 1'b0, 1'b1, 6'd0, 32'h0, "R3");
    rd(6'd0, "R3");
    step('0, '0, 1'b0, 1'b1, 6'd2, 32'h0F0F_0F0F, "R3");
    rd(6'd2, "R3");

    // R5: set and clear together, overflow 0 before
    step(32'hFFFF_FFFF, '0, 1'b0, 1'b1, 6'd0, 32'hFFFF_FFFF, "R5");
    rd(6'd0, "R5");
    rd(6'd1, "R5");
    // make overflow 1, then set and clear together again
    step(32'hFFFF_FFFF, '0, 1'b0, 1'b0, 6'd7, '0, "R2");
    step(32'hFFFF_FFFF, '0, 1'b0, 1'b1, 6'd0, 32'hFFFF_FFFF, "R5");
    rd(6'd1, "R5");
    rd(6'd0, "R5");

    // R6: overflow clear meets a new overflow condition on even channels
    step(32'h5555_5555, '0, 1'b0, 1'b1, 6'd1, 32'hFFFF_FFFF, "R6");
    rd(6'd1, "R6");

    // R8: enables through vector and channel register
    step('0, '0, 1'b0, 1'b1, 6'd4, 32'hA5A5_A5A5, "R8");
    step('0, '0, 1'b0, 1'b1, 6'd5, 32'h3C3C_C3C3, "R8");
    step('0, '0, 1'b0, 1'b1, 6'd35, 32'h30, "R8");
    step('0, '0, 1'b0, 1'b1, 6'd36, 32'h00, "R8");
    rd(6'd4, "R8");
    rd(6'd5, "R8");
    step(32'h00FF_00FF, 32'hF0F0_F0F0, 1'b0, 1'b0, 6'd35, '0, "R8");

    // R10: exception flag
    step('0, '0, 1'b1, 1'b0, 6'd6, '0, "R10");
    step('0, '0, 1'b0, 1'b1, 6'd6, 32'hFFFF_FFFE, "R10");
    step('0, '0, 1'b1, 1'b1, 6'd6, 32'h1, "R10");
    rd(6'd6, "R10");
    step('0, '0, 1'b0, 1'b1, 6'd6, 32'hFFFF_FFFF, "R10");
    step('0, '0, 1'b1, 1'b0, 6'd7, '0, "R10");
    step('0, '0, 1'b1, 1'b0, 6'd6, '0, "R10");
    rd(6'd6, "R10");

    // R9: pseudo-random mix of pulses, writes and reads
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r1 = nextRnd();
      logic [31:0] r2 = nextRnd();
      logic [31:0] r3 = nextRnd();
      logic [31:0] r4 = nextRnd();
      logic [5:0]  a  = r4[8] ? {3'b000, r4[2:0]} : {1'b1, r4[7:3]};
      step(r1 & r2 & r3, r2 & r3 & r4, r1[0] & r2[0], r4[9], a, nextRnd(), "R9");
    end

    finished = 1;
    summary();
  end

endmodule